// File: doc/BRIEF.md
# Flash Write-Cycle Capture Front End

This block sits between the asynchronous control pins of a parallel flash bus and the synchronous command controller inside the device. A fast system clock oversamples chip enable, write enable and output enable. The block finds bus write cycles, rejects strobe pulses too short to be real and blocks writes after power-up, while the supply-low flag is raised and while the device reset pin is held. For each accepted cycle it hands the controller a one-clock strobe with the captured address and data.

A write cycle is the period in which chip enable and write enable are both low while output enable is high. The address is taken when the cycle opens, which is the later of the two falling edges. The data is taken when the cycle closes, which is the earlier of the two rising edges. In byte mode the top data pin serves as an extra least significant address bit, and only the low data byte is kept. The block also drives the tristate enables of the two data-pin halves for reads.

Top module: `flash_wr_capture`

## Requirements
- R1: A write is recognised only while ce_n and we_n are both low and oe_n is high. If oe_n is low for the whole low period, or falls before ce_n or we_n returns high, no wr_strobe is produced.
- R2: wr_addr[AW:1] holds the addr value sampled in the first clock in which the synchronised ce_n and we_n are both low. Later changes of addr during the cycle have no effect.
- R3: wr_data holds the dq_in value sampled in the first clock in which ce_n or we_n is seen high again. This applies to a cycle closed by we_n and to one closed by ce_n.
- R4: A joint low period of fewer than MIN_W samples produces no wr_strobe. A period of MIN_W samples or more produces exactly one.
- R5: After rst_n is released, or after supply_low or pin_rst_n has blocked the bus, no write is accepted until a sample is seen in which the write condition is false.
- R6: While supply_low is high or pin_rst_n is low, writes are ignored and ctl_rst_req is high. ctl_rst_req follows these inputs two clocks later. It is high during and right after rst_n.
- R7: When byte_n is low at the opening of the cycle, wr_byte=1, wr_addr[0]=dq_in[DW-1] and wr_data[DW-1:DW/2]=0. When byte_n is high, wr_byte=0, wr_addr[0]=0 and all of wr_data is taken.
- R8: dq_lo_oe is high exactly when oe_n=0, ce_n=0 and pin_rst_n=1. dq_hi_oe is dq_lo_oe gated by byte_n=1. Both are combinational from the pins.
- R9: wr_strobe is a one-clock pulse. It is high during the clock that starts at the second rising edge after the edge that first samples the closing strobe. It is low during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Active-low reset of the clocked logic |
| ce_n | input | 1 | Chip enable pin, active low |
| we_n | input | 1 | Write enable pin, active low |
| oe_n | input | 1 | Output enable pin, active low |
| byte_n | input | 1 | Low selects byte mode |
| pin_rst_n | input | 1 | Device reset pin, active low |
| supply_low | input | 1 | Digital supply-lockout flag |
| addr | input | AW | Address pins |
| dq_in | input | DW | Data pins as seen by the input buffers |
| wr_strobe | output | 1 | One-clock write event to the controller |
| wr_addr | output | AW+1 | Captured address; bit 0 is the byte-select bit |
| wr_data | output | DW | Captured write data |
| wr_byte | output | 1 | Captured cycle was in byte mode |
| dq_lo_oe | output | 1 | Drive enable for the low data byte |
| dq_hi_oe | output | 1 | Drive enable for the high data byte |
| ctl_rst_req | output | 1 | Reset request to the controller |

## Verification
Every pin sample passes two synchroniser stages before it is acted on. As a result, ctl_rst_req reflects the pins two clocks late, and wr_strobe rises two clocks after the edge that first samples the closing strobe. The read enables react in the same instant as the pins. The bench model records the clock number of every sampled edge. It schedules each expected strobe at that edge number plus two and expects the reset request from the sample two edges back. Pins change on falling edges, and all outputs are compared a quarter period after each rising edge, so that every registered result has settled and no pin changes at the moment of comparison.

// File: rtl/flash_wr_capture.sv
module flash_wr_capture #(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int MIN_W = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic          byte_n,
  input  logic          pin_rst_n,
  input  logic          supply_low,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dq_in,
  output logic          wr_strobe,
  output logic [AW:0]   wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          wr_byte,
  output logic          dq_lo_oe,
  output logic          dq_hi_oe,
  output logic          ctl_rst_req
);
  localparam int HW = DW / 2;
  localparam int CW = $clog2(MIN_W + 1);
  localparam int PW = 1 + DW + AW;
  localparam logic [4:0] SYNC_IDLE = 5'b10111;

  logic [4:0]    s1, s2;
  logic [PW-1:0] p1, p2;
  logic [CW-1:0] cnt;
  logic          pu_block, cap_byte;
  logic [AW:0]   cap_addr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= SYNC_IDLE;
      s2 <= SYNC_IDLE;
      p1 <= '0;
      p2 <= '0;
    end else begin
      s1 <= {supply_low, pin_rst_n, oe_n, we_n, ce_n};
      s2 <= s1;
      p1 <= {byte_n, dq_in, addr};
      p2 <= p1;
    end

  logic          ce2, we2, oe2, prst2, lock2, byte2;
  logic [DW-1:0] dq2;
  logic [AW-1:0] a2;
  assign {lock2, prst2, oe2, we2, ce2} = s2;
  assign {byte2, dq2, a2} = p2;

  logic wact, bus_ok, ok, act, full, fin;
  assign wact   = !ce2 && !we2 && oe2;
  assign bus_ok = !lock2 && prst2;
  assign ok     = bus_ok && !pu_block;
  assign act    = wact && ok;
  assign full   = (cnt == CW'(MIN_W));
  assign fin    = full && !wact && oe2 && ok;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pu_block  <= 1'b1;
      cnt       <= '0;
      cap_addr  <= '0;
      cap_byte  <= 1'b0;
      wr_strobe <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      wr_byte   <= 1'b0;
    end else begin
      if (!bus_ok)     pu_block <= 1'b1;
      else if (!wact)  pu_block <= 1'b0;

      if (act) begin
        if (!full) cnt <= cnt + 1'b1;
        if (cnt == '0) begin
          cap_byte <= !byte2;
          cap_addr <= {a2, !byte2 && dq2[DW-1]};
        end
      end else begin
        cnt <= '0;
      end

      wr_strobe <= fin;
      if (fin) begin
        wr_addr <= cap_addr;
        wr_byte <= cap_byte;
        wr_data <= cap_byte ? {{HW{1'b0}}, dq2[HW-1:0]} : dq2;
      end
    end

  assign ctl_rst_req = !bus_ok;
  assign dq_lo_oe    = !oe_n && !ce_n && pin_rst_n;
  assign dq_hi_oe    = dq_lo_oe && byte_n;
endmodule

// File: rtl/flash_wr_capture_chk.sv
module flash_wr_capture_chk #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          oe_n,
  input logic          byte_n,
  input logic          wr_strobe,
  input logic [AW:0]   wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          wr_byte,
  input logic          dq_lo_oe,
  input logic          dq_hi_oe,
  input logic          ctl_rst_req
);
  localparam int HW = DW / 2;

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |=> !wr_strobe);

  assert_no_write_in_lockout_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rst_req |=> !wr_strobe);

  assert_byte_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && wr_byte) |-> (wr_data[DW-1:HW] == '0));

  assert_word_lsb_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && !wr_byte) |-> !wr_addr[0]);

  assert_oe_pin_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_lo_oe && !dq_hi_oe);

  assert_hi_needs_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dq_hi_oe |-> dq_lo_oe && byte_n);
endmodule

bind flash_wr_capture flash_wr_capture_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .byte_n(byte_n),
  .wr_strobe(wr_strobe), .wr_addr(wr_addr), .wr_data(wr_data),
  .wr_byte(wr_byte), .dq_lo_oe(dq_lo_oe), .dq_hi_oe(dq_hi_oe),
  .ctl_rst_req(ctl_rst_req)
);

// File: tb/flash_wr_capture_tb.sv
module flash_wr_capture_tb;
  localparam int CLK_P = 10;
  localparam int AW = 16, DW = 16, MIN_W = 3;

  logic clk = 0, rst_n = 0;
  logic ce_n = 1, we_n = 1, oe_n = 1, byte_n = 1, pin_rst_n = 1, supply_low = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic wr_strobe, wr_byte, dq_lo_oe, dq_hi_oe, ctl_rst_req;
  logic [AW:0] wr_addr;
  logic [DW-1:0] wr_data;

  always #(CLK_P/2) clk = ~clk;

  flash_wr_capture #(.AW(AW), .DW(DW), .MIN_W(MIN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .byte_n(byte_n), .pin_rst_n(pin_rst_n), .supply_low(supply_low),
    .addr(addr), .dq_in(dq_in), .wr_strobe(wr_strobe), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_byte(wr_byte), .dq_lo_oe(dq_lo_oe),
    .dq_hi_oe(dq_hi_oe), .ctl_rst_req(ctl_rst_req));

  typedef struct { int due; logic [AW:0] a; logic [DW-1:0] d; logic b; } ev_t;
  ev_t evq[$];
  int cyc = 0, run = 0, nchk = 0, nerr = 0, nstb = 0;
  bit blocked = 1, rq0 = 1, rqm1 = 1, done = 0;
  logic [AW:0] st_a;
  logic st_b;
  string cur_req = "R9";

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // behavioural model of the pin samples, one step per rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      evq.delete(); run = 0; blocked = 1; rq0 = 1; rqm1 = 1;
    end else begin
      bit active, good;
      cyc++;
      active = !ce_n && !we_n && oe_n;
      good = !supply_low && pin_rst_n;
      rqm1 = rq0; rq0 = !good;
      if (!good) begin blocked = 1; run = 0; end
      else if (blocked) begin if (!active) blocked = 0; run = 0; end
      else if (active) begin
        if (run == 0) begin st_a = {addr, !byte_n && dq_in[DW-1]}; st_b = !byte_n; end
        if (run < MIN_W) run++;
      end else begin
        if (run >= MIN_W && oe_n) begin
          ev_t e;
          e.due = cyc + 2; e.a = st_a; e.b = st_b;
          e.d = st_b ? {8'h00, dq_in[7:0]} : dq_in;
          evq.push_back(e);
        end
        run = 0;
      end
    end
  end

  always @(posedge clk) begin
    #(CLK_P/4);
    if (rst_n && !done) begin
      bit es;
      es = (evq.size() > 0) && (evq[0].due == cyc);
      chk(cur_req, "wr_strobe", 32'(wr_strobe), 32'(es));
      if (wr_strobe) nstb++;
      if (es) begin
        chk("R2", "wr_addr[AW:1]", 32'(wr_addr[AW:1]), 32'(evq[0].a[AW:1]));
        chk("R7", "wr_addr[0]", 32'(wr_addr[0]), 32'(evq[0].a[0]));
        chk("R3", "wr_data", 32'(wr_data), 32'(evq[0].d));
        chk("R7", "wr_byte", 32'(wr_byte), 32'(evq[0].b));
        void'(evq.pop_front());
      end
      chk("R6", "ctl_rst_req", 32'(ctl_rst_req), 32'(rqm1));
      chk("R8", "dq_lo_oe", 32'(dq_lo_oe), 32'(!oe_n && !ce_n && pin_rst_n));
      chk("R8", "dq_hi_oe", 32'(dq_hi_oe), 32'(!oe_n && !ce_n && pin_rst_n && byte_n));
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // mode 0: ce_n falls first, we_n closes; mode 1: we_n falls first, ce_n closes
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                    input int w, input bit mode);
    @(negedge clk); addr = a; dq_in = d0;
    if (mode) we_n = 0; else ce_n = 0;
    @(negedge clk);
    if (mode) ce_n = 0; else we_n = 0;
    @(negedge clk); addr = ~a;
    repeat (w - 1) @(negedge clk);
    dq_in = d1;
    if (mode) ce_n = 1; else we_n = 1;
    @(negedge clk); dq_in = 16'hDEAD;
    if (mode) we_n = 1; else ce_n = 1;
    idle(4);
  endtask

  initial begin
    #(CLK_P * 100000);
    nerr++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end

  initial begin
    int base;
    idle(3);
    chk("R9", "reset wr_strobe", 32'(wr_strobe), 0);
    chk("R6", "reset ctl_rst_req", 32'(ctl_rst_req), 1);
    rst_n = 1;
    idle(5);

    cur_req = "R2"; base = nstb;
    wr(16'h1234, 16'h0000, 16'hA5C3, 5, 0);
    chk("R1", "strobes after write closed by we_n", 32'(nstb - base), 1);
    cur_req = "R3"; base = nstb;
    wr(16'h8001, 16'h1111, 16'h5AA5, 4, 1);
    chk("R3", "strobes after write closed by ce_n", 32'(nstb - base), 1);

    cur_req = "R1"; base = nstb;
    @(negedge clk); oe_n = 0; ce_n = 0; we_n = 0; idle(6);
    ce_n = 1; we_n = 1; idle(1); oe_n = 1; idle(4);
    wr_oe_drop();
    chk("R1", "strobes with oe_n low", 32'(nstb - base), 0);

    cur_req = "R4"; base = nstb;
    wr(16'h0F0F, 16'h0, 16'h7777, MIN_W - 1, 0);
    chk("R4", "strobes for short pulse", 32'(nstb - base), 0);
    wr(16'h0F10, 16'h0, 16'h8888, MIN_W, 1);
    chk("R4", "strobes for MIN_W pulse", 32'(nstb - base), 1);

    cur_req = "R7"; byte_n = 0; base = nstb;
    wr(16'hBEEF, 16'h8000, 16'hFF3C, 4, 0);
    wr(16'h4321, 16'h0000, 16'h7F81, 4, 1);
    chk("R7", "byte-mode strobes", 32'(nstb - base), 2);
    oe_n = 0; ce_n = 0; idle(2);
    ce_n = 1; oe_n = 1; byte_n = 1;
    oe_n = 0; ce_n = 0; idle(2);
    ce_n = 1; oe_n = 1; idle(2);

    cur_req = "R6"; base = nstb;
    @(negedge clk); supply_low = 1; ce_n = 0; we_n = 0; idle(6);
    we_n = 1; ce_n = 1; idle(2); supply_low = 0; idle(3);
    @(negedge clk); ce_n = 0; we_n = 0; idle(3); pin_rst_n = 0; idle(2);
    oe_n = 0; idle(2); oe_n = 1; we_n = 1; ce_n = 1; idle(2); pin_rst_n = 1; idle(4);
    chk("R6", "strobes while blocked", 32'(nstb - base), 0);
    @(negedge clk); ce_n = 0; we_n = 0; supply_low = 1; idle(1); supply_low = 0; idle(5);
    we_n = 1; ce_n = 1; idle(4);
    chk("R5", "strobes after lockout pulse with strobes low", 32'(nstb - base), 0);

    cur_req = "R5"; base = nstb;
    @(negedge clk); rst_n = 0; ce_n = 0; we_n = 0; oe_n = 1; idle(3);
    rst_n = 1; idle(6);
    we_n = 1; idle(1); ce_n = 1; idle(4);
    chk("R5", "strobes after power-up with write held", 32'(nstb - base), 0);
    wr(16'h2468, 16'h0, 16'h1357, 3, 0);
    chk("R5", "strobes after release", 32'(nstb - base), 1);

    idle(4);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end

  task automatic wr_oe_drop();
    @(negedge clk); addr = 16'h5555; ce_n = 0; we_n = 0; idle(2);
    oe_n = 0; idle(4);
    we_n = 1; ce_n = 1; idle(1); oe_n = 1; idle(4);
  endtask
endmodule